// File: doc/BRIEF.md
# Receive Auto-Acknowledge Controller

This controller decides, at the end of every received frame, whether the frame is accepted and whether an acknowledgement must be sent back, then times that acknowledgement on the symbol grid. It does not filter addresses or compute the checksum itself. It takes the filter and checksum verdicts, the frame type, the ACK-request and broadcast flags and the command identifier, all valid in the cycle where `rx_eof` pulses. From those it produces a transaction status, an end-of-frame interrupt and a transmit-start strobe for the modem.

Two launch modes exist. In unslotted operation the acknowledgement starts after a fixed turnaround counted in symbol ticks. In slotted operation the controller arms itself and waits, reporting "success, waiting", until a rising edge on an external trigger pin starts the transmission. The pending flag placed in the outgoing acknowledgement is taken from the configuration only when the frame was a data-request command. It is sampled at the moment the acknowledgement is launched, so the configuration may be changed while the frame is still being processed.

Top module: `rx_autoack_ctrl`

## Requirements
- R1: A frame is accepted only when `fcs_ok` is 1 and either `addr_ok` is 1, or `no_dst` and `cfg_coord` are both 1. An accepted frame seen in the listen state pulses `eof_irq` for one cycle and updates `trac_status` one clock after the `rx_eof` cycle. A rejected frame produces neither.
- R2: An accepted frame with `ack_req`=0, or with `dst_bcast`=1, sets `trac_status` to 2'b00 (success), leaves `radio_state` at 2'b00 (listen) and never pulses `tx_start`.
- R3: In unslotted mode (`cfg_slotted`=0), an accepted frame needing an ACK sets status 2'b00 and `radio_state` 2'b01 (turnaround). `tx_start` pulses for one cycle one clock after the 12th `sym_tick`, and `radio_state` becomes 2'b11 (ACK transmit).
- R4: The ACK transmit state lasts 22 `sym_tick`s in either mode. One clock after the 22nd tick, `radio_state` returns to 2'b00.
- R5: In slotted mode, an accepted frame needing an ACK sets status 2'b01 (success, wait for ACK) and `radio_state` 2'b10 (armed). The controller stays armed for any number of symbol ticks.
- R6: While armed, a rising edge on `trig_pin` pulses `tx_start` and enters state 2'b11. This happens SYNC_STAGES+1 clocks after the pin is first sampled high.
- R7: A rising edge on `trig_pin` in any state other than armed is ignored: no `tx_start` and no state change.
- R8: `rx_start` while armed aborts the transaction. One clock later `trac_status` is 2'b11 (invalid), `radio_state` is 2'b00, and no interrupt is raised.
- R9: `ack_pend` at the `tx_start` pulse equals `cfg_pend` only when the frame had `frame_type`=3'b011 (command) and `cmd_id`=8'h04 (data request). For any other frame, including a data frame with `frame_type`=3'b001, it is 0.
- R10: The `cfg_pend` value used is the one present in the cycle in which the launch is decided, not the one present at `rx_eof`.
- R11: `rx_eof` arriving while `radio_state` is not 2'b00 is ignored: no interrupt and no state change.
- R12: After reset, `radio_state` and `trac_status` are 2'b00 and `eof_irq`, `tx_start` and `ack_pend` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_tick | input | 1 | One-cycle pulse per symbol period |
| rx_start | input | 1 | Start of a new incoming frame |
| rx_eof | input | 1 | Last symbol of a frame received; verdict inputs valid |
| addr_ok | input | 1 | Address filter passed |
| no_dst | input | 1 | Frame carries no destination address |
| fcs_ok | input | 1 | Checksum correct |
| frame_type | input | 3 | Frame type field |
| ack_req | input | 1 | Frame requests acknowledgement |
| dst_bcast | input | 1 | Destination is the broadcast address |
| cmd_id | input | 8 | Command identifier of a command frame |
| cfg_coord | input | 1 | Operate as network coordinator |
| cfg_slotted | input | 1 | Slotted launch mode |
| cfg_pend | input | 1 | Pending-data setting for ACKs |
| trig_pin | input | 1 | External ACK launch trigger (asynchronous) |
| trac_status | output | 2 | 00 success, 01 success-wait, 11 invalid |
| eof_irq | output | 1 | One-cycle end-of-frame interrupt |
| tx_start | output | 1 | One-cycle ACK transmit start strobe |
| ack_pend | output | 1 | Frame-pending bit for the ACK |
| radio_state | output | 2 | 00 listen, 01 turnaround, 10 armed, 11 ACK transmit |

## Verification
Interrupt and status are due one clock after the `rx_eof` cycle. A symbol-timed transition is due one clock after the tick that completes the count. A trigger launch is due SYNC_STAGES+1 clocks after the pin rises, and an abort is due one clock after `rx_start`. The bench drives every input, ticks included, on falling edges and reads the outputs on the next falling edge after the edge that should change them. It counts ticks itself, so each check lands on exactly one cycle. A free-running monitor counts `tx_start` pulses, so a launch that should never happen is caught whenever it occurs.

// File: rtl/rxaa_pkg.sv
package rxaa_pkg;

  typedef enum logic [1:0] {
    ST_LISTEN = 2'b00,
    ST_TURN   = 2'b01,
    ST_ARMED  = 2'b10,
    ST_ACKTX  = 2'b11
  } rxaa_state_e;

  typedef enum logic [1:0] {
    TS_SUCCESS  = 2'b00,
    TS_WAIT_ACK = 2'b01,
    TS_RSVD     = 2'b10,
    TS_INVALID  = 2'b11
  } rxaa_trac_e;

  localparam logic [2:0] FT_CMD       = 3'b011;
  localparam logic [7:0] CMD_DATA_REQ = 8'h04;

  typedef struct packed {
    logic accept;
    logic need_ack;
    logic dreq;
  } rxaa_verdict_t;

endpackage

// File: rtl/rxaa_verdict.sv
module rxaa_verdict
  import rxaa_pkg::*;
(
  input  logic          addr_ok,
  input  logic          no_dst,
  input  logic          fcs_ok,
  input  logic          cfg_coord,
  input  logic          ack_req,
  input  logic          dst_bcast,
  input  logic [2:0]    frame_type,
  input  logic [7:0]    cmd_id,
  output rxaa_verdict_t verdict
);

  logic addr_pass;

  // a frame without destination address is only for the coordinator
  assign addr_pass        = addr_ok | (no_dst & cfg_coord);
  assign verdict.accept   = fcs_ok & addr_pass;
  assign verdict.need_ack = verdict.accept & ack_req & ~dst_bcast;
  assign verdict.dreq     = (frame_type == FT_CMD) && (cmd_id == CMD_DATA_REQ);

endmodule

// File: rtl/rxaa_trig_edge.sv
module rxaa_trig_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);

  logic lvl;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign lvl = pin;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sync_q <= '0;
        end else begin
          sync_q[0] <= pin;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            sync_q[i] <= sync_q[i-1];
          end
        end
      end
      assign lvl = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R6
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

endmodule

// File: rtl/rxaa_sym_timer.sv
module rxaa_sym_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt;

  assign done = tick && !clr && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (done)   cnt <= '0;
    else if (tick)   cnt <= cnt + CW'(1);
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (limit != '0) |-> (cnt < limit));

endmodule

// File: rtl/rx_autoack_ctrl.sv
module rx_autoack_ctrl
  import rxaa_pkg::*;
#(
  parameter int TURN_SYM    = 12,
  parameter int ACK_SYM     = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_tick,
  input  logic       rx_start,
  input  logic       rx_eof,
  input  logic       addr_ok,
  input  logic       no_dst,
  input  logic       fcs_ok,
  input  logic [2:0] frame_type,
  input  logic       ack_req,
  input  logic       dst_bcast,
  input  logic [7:0] cmd_id,
  input  logic       cfg_coord,
  input  logic       cfg_slotted,
  input  logic       cfg_pend,
  input  logic       trig_pin,
  output logic [1:0] trac_status,
  output logic       eof_irq,
  output logic       tx_start,
  output logic       ack_pend,
  output logic [1:0] radio_state
);

  localparam int MAX_SYM = (TURN_SYM > ACK_SYM) ? TURN_SYM : ACK_SYM;
  localparam int CW      = $clog2(MAX_SYM + 1);

  rxaa_state_e   state;
  rxaa_trac_e    trac_q;
  rxaa_verdict_t verdict;
  logic          dreq_q;
  logic          trig_rise;
  logic          tmr_clr;
  logic          tmr_done;
  logic [CW-1:0] tmr_limit;

  rxaa_verdict u_verdict (
    .addr_ok    (addr_ok),
    .no_dst     (no_dst),
    .fcs_ok     (fcs_ok),
    .cfg_coord  (cfg_coord),
    .ack_req    (ack_req),
    .dst_bcast  (dst_bcast),
    .frame_type (frame_type),
    .cmd_id     (cmd_id),
    .verdict    (verdict)
  );

  rxaa_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk  (clk),
    .rst  (rst),
    .pin  (trig_pin),
    .rise (trig_rise)
  );

  assign tmr_clr   = (state == ST_LISTEN) || (state == ST_ARMED);
  assign tmr_limit = (state == ST_TURN) ? CW'(TURN_SYM) : CW'(ACK_SYM);

  rxaa_sym_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .tick  (sym_tick),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LISTEN;
      trac_q   <= TS_SUCCESS;
      eof_irq  <= 1'b0;
      tx_start <= 1'b0;
      ack_pend <= 1'b0;
      dreq_q   <= 1'b0;
    end else begin
      eof_irq  <= 1'b0;
      tx_start <= 1'b0;
      case (state)
        ST_LISTEN: begin
          if (rx_eof && verdict.accept) begin
            eof_irq <= 1'b1;
            dreq_q  <= verdict.dreq;
            if (verdict.need_ack && cfg_slotted) begin
              trac_q <= TS_WAIT_ACK;
              state  <= ST_ARMED;
            end else if (verdict.need_ack) begin
              trac_q <= TS_SUCCESS;
              state  <= ST_TURN;
            end else begin
              trac_q <= TS_SUCCESS;
            end
          end
        end
        ST_TURN: begin
          if (tmr_done) begin
            state    <= ST_ACKTX;
            tx_start <= 1'b1;
            ack_pend <= dreq_q & cfg_pend;
          end
        end
        ST_ARMED: begin
          if (rx_start) begin
            trac_q <= TS_INVALID;
            state  <= ST_LISTEN;
          end else if (trig_rise) begin
            state    <= ST_ACKTX;
            tx_start <= 1'b1;
            ack_pend <= dreq_q & cfg_pend;
          end
        end
        ST_ACKTX: begin
          if (tmr_done) state <= ST_LISTEN;
        end
        default: state <= ST_LISTEN;
      endcase
    end
  end

  assign trac_status = trac_q;
  assign radio_state = state;

  // R1
  irq_after_eof_chk: assert property (@(posedge clk) disable iff (rst)
    eof_irq |-> $past(rx_eof));

  // R3
  strobe_in_tx_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (state == ST_ACKTX));

  // R7
  strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> ($past(state) == ST_TURN || $past(state) == ST_ARMED));

  // R5
  armed_status_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED) |-> (trac_q == TS_WAIT_ACK));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && rx_start) |=> (state == ST_LISTEN && trac_q == TS_INVALID && !eof_irq));

  // R9
  pend_only_dreq_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_start && !dreq_q) |-> !ack_pend);

  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

endmodule

// File: tb/sim_rx_autoack_ctrl.sv
module sim_rx_autoack_ctrl;

  localparam int TURN = 12;
  localparam int ACKL = 22;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_tick = 0, rx_start = 0, rx_eof = 0, addr_ok = 0, no_dst = 0, fcs_ok = 0;
  logic [2:0] frame_type = 3'b001;
  logic ack_req = 0, dst_bcast = 0;
  logic [7:0] cmd_id = 8'h00;
  logic cfg_coord = 0, cfg_slotted = 0, cfg_pend = 0, trig_pin = 0;
  logic [1:0] trac_status, radio_state;
  logic eof_irq, tx_start, ack_pend;

  int checks = 0;
  int fails  = 0;
  int txcnt  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  rx_autoack_ctrl #(.TURN_SYM(TURN), .ACK_SYM(ACKL), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .sym_tick(sym_tick), .rx_start(rx_start), .rx_eof(rx_eof),
    .addr_ok(addr_ok), .no_dst(no_dst), .fcs_ok(fcs_ok), .frame_type(frame_type),
    .ack_req(ack_req), .dst_bcast(dst_bcast), .cmd_id(cmd_id), .cfg_coord(cfg_coord),
    .cfg_slotted(cfg_slotted), .cfg_pend(cfg_pend), .trig_pin(trig_pin),
    .trac_status(trac_status), .eof_irq(eof_irq), .tx_start(tx_start),
    .ack_pend(ack_pend), .radio_state(radio_state)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (tx_start) txcnt <= txcnt + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_eof(input logic a, input logic nd, input logic f, input logic [2:0] ft,
                          input logic ar, input logic bc, input logic [7:0] cid);
    @(negedge clk);
    addr_ok = a; no_dst = nd; fcs_ok = f; frame_type = ft;
    ack_req = ar; dst_bcast = bc; cmd_id = cid; rx_eof = 1'b1;
    @(negedge clk);
    rx_eof = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sym_tick = 1'b1;
      @(negedge clk) sym_tick = 1'b0;
    end
  endtask

  task automatic trig_launch();
    @(negedge clk) trig_pin = 1'b1;
    repeat (SYNC + 1) @(negedge clk);
  endtask

  task automatic trig_release();
    trig_pin = 1'b0;
    repeat (SYNC + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 state", radio_state, 0);
    chk("R12 status", trac_status, 0);
    chk("R12 irq", eof_irq, 0);
    chk("R12 tx_start", tx_start, 0);
    chk("R12 ack_pend", ack_pend, 0);
  endtask

  task automatic t_reject();
    cfg_coord = 0;
    send_eof(1, 0, 0, 3'b001, 1, 0, 8'h00);
    chk("R1 bad fcs irq", eof_irq, 0);
    chk("R1 bad fcs state", radio_state, 0);
    send_eof(0, 0, 1, 3'b001, 1, 0, 8'h00);
    chk("R1 bad addr irq", eof_irq, 0);
    send_eof(0, 1, 1, 3'b001, 0, 0, 8'h00);
    chk("R1 no dst device irq", eof_irq, 0);
    cfg_coord = 1;
    send_eof(0, 1, 1, 3'b001, 0, 0, 8'h00);
    chk("R1 no dst coord irq", eof_irq, 1);
    chk("R1 no dst coord status", trac_status, 0);
    @(negedge clk);
    chk("R1 irq one cycle", eof_irq, 0);
    cfg_coord = 0;
  endtask

  task automatic t_noack();
    int base;
    base = txcnt;
    cfg_slotted = 0;
    send_eof(1, 0, 1, 3'b001, 0, 0, 8'h00);
    chk("R2 irq", eof_irq, 1);
    chk("R2 status", trac_status, 0);
    chk("R2 state", radio_state, 0);
    send_eof(1, 0, 1, 3'b001, 1, 1, 8'h00);
    chk("R2 bcast state", radio_state, 0);
    ticks(TURN + ACKL + 2);
    chk("R2 no strobe", txcnt - base, 0);
  endtask

  task automatic t_unslotted_data();
    cfg_slotted = 0; cfg_pend = 1;
    send_eof(1, 0, 1, 3'b001, 1, 0, 8'h00);
    chk("R3 irq", eof_irq, 1);
    chk("R3 status", trac_status, 0);
    chk("R3 turnaround state", radio_state, 1);
    ticks(TURN - 1);
    chk("R3 no early strobe", tx_start, 0);
    chk("R3 still turnaround", radio_state, 1);
    ticks(1);
    chk("R3 strobe", tx_start, 1);
    chk("R3 tx state", radio_state, 3);
    chk("R9 data frame pend", ack_pend, 0);
    ticks(ACKL - 1);
    chk("R4 still tx", radio_state, 3);
    ticks(1);
    chk("R4 back to listen", radio_state, 0);
    cfg_pend = 0;
  endtask

  task automatic t_unslotted_dreq();
    int base;
    cfg_slotted = 0; cfg_pend = 0;
    send_eof(1, 0, 1, 3'b011, 1, 0, 8'h04);
    ticks(3);
    // R11: a second frame end during turnaround is ignored
    send_eof(1, 0, 1, 3'b001, 0, 0, 8'h00);
    chk("R11 irq ignored", eof_irq, 0);
    chk("R11 state kept", radio_state, 1);
    cfg_pend = 1;
    ticks(TURN - 3);
    chk("R10 strobe", tx_start, 1);
    chk("R10 late pend used", ack_pend, 1);
    ticks(ACKL);
    chk("R4 listen again", radio_state, 0);
    cfg_pend = 1;
    send_eof(1, 0, 1, 3'b011, 1, 0, 8'h05);
    ticks(TURN);
    chk("R9 other cmd pend", ack_pend, 0);
    ticks(ACKL);
    cfg_pend = 0;
    send_eof(1, 0, 1, 3'b011, 1, 0, 8'h04);
    ticks(TURN);
    chk("R9 dreq pend clear", ack_pend, 0);
    ticks(ACKL);
    base = txcnt;
    chk("R4 idle", radio_state, 0);
    chk("R3 strobe count stable", txcnt - base, 0);
  endtask

  task automatic t_slotted();
    int base;
    cfg_slotted = 1; cfg_pend = 1;
    send_eof(1, 0, 1, 3'b011, 1, 0, 8'h04);
    chk("R5 irq", eof_irq, 1);
    chk("R5 status wait", trac_status, 1);
    chk("R5 armed", radio_state, 2);
    base = txcnt;
    ticks(40);
    chk("R5 still armed", radio_state, 2);
    chk("R5 no strobe", txcnt - base, 0);
    trig_launch();
    chk("R6 strobe", tx_start, 1);
    chk("R6 tx state", radio_state, 3);
    chk("R9 slotted dreq pend", ack_pend, 1);
    trig_release();
    ticks(ACKL - 1);
    chk("R4 slotted still tx", radio_state, 3);
    ticks(1);
    chk("R4 slotted listen", radio_state, 0);
    cfg_pend = 0;
  endtask

  task automatic t_trig_ignored();
    int base;
    base = txcnt;
    trig_launch();
    repeat (3) @(negedge clk);
    chk("R7 no strobe", txcnt - base, 0);
    chk("R7 state", radio_state, 0);
    trig_release();
  endtask

  task automatic t_abort();
    int base;
    cfg_slotted = 1;
    send_eof(1, 0, 1, 3'b001, 1, 0, 8'h00);
    chk("R8 armed", radio_state, 2);
    @(negedge clk) rx_start = 1'b1;
    @(negedge clk) rx_start = 1'b0;
    chk("R8 status invalid", trac_status, 3);
    chk("R8 state listen", radio_state, 0);
    chk("R8 no irq", eof_irq, 0);
    base = txcnt;
    trig_launch();
    repeat (3) @(negedge clk);
    chk("R7 after abort no strobe", txcnt - base, 0);
    trig_release();
    cfg_slotted = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reject();
    t_noack();
    t_unslotted_data();
    t_unslotted_dreq();
    t_slotted();
    t_trig_ignored();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule